// File: doc/BRIEF.md
# Core Module System Control Register File

This block is the system control register file for a processor core module. It sits on a simple 32-bit register bus that is addressed by word. Reads return data combinationally from the current word address. A write takes effect on the rising clock edge while select and write are both high. The block holds fixed identification and status words and a control register. The control register drives an LED, chooses whether boot flash or RAM appears at address zero, and can request a system reset.

Two oscillator setting registers can only be changed after software writes a 16-bit unlock key to the lock register. The block also has two flag registers, one volatile and one non-volatile. Each has its own set port and clear port. A 32-bit reference counter advances once for every reference tick. The tick is a strobe that the system supplies once per 24 MHz reference period, so everything runs from one system clock. A 32-word window returns a read-only memory-module descriptor. The module size comes from the `MEM_MB` parameter.

Top module: `cm_sysctl`

## Requirements
- R1: Word 0 reads 0x411A3001, word 1 reads 0 and word 4 reads 0x00100000. Every word not named in R1 to R10, including the descriptor tail at words 96 to 127, reads 0. Writes to those words change nothing.
- R2: A write to word 5 (lock) stores data bits 15:0. A read of word 5 returns 0x0001A05F when the stored value is 0xA05F, and the zero-extended stored value otherwise.
- R3: Words 2 (oscillator) and 7 (auxiliary oscillator) are full 32-bit registers. A write to either one updates it only while the lock holds 0xA05F; at any other time the write leaves the value that reads back unchanged.
- R4: In word 3 (control), bit 0 (LED) and bit 2 (remap) are stored and every other bit reads 0. `ledOn` follows bit 0. `flashAtZero` is high while bit 2 is clear.
- R5: A write to word 3 with data bit 3 set makes `resetReq` high for exactly one clock, starting at the write edge. Bit 3 always reads back 0.
- R6: Word 12 reads the flags. A write to word 12 ORs the data into them and a write to word 13 clears the bits that are 1 in the data. Words 14 and 15 do the same for the non-volatile flags, independently of words 12 and 13.
- R7: Word 10 reads a 32-bit counter. It is 0 after reset, adds 1 on each clock edge where `refTick` is high, and wraps.
- R8: Reset values are as follows:
  - oscillator: 0x01000048
  - auxiliary oscillator: 0x0007FEFF
  - SDRAM control: 0x00011122 ORed with a size code of 0x10 for `MEM_MB` of 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 otherwise
  - init: 0x00000112
  - control, lock and both flag registers: 0
- R9: Words 8 (SDRAM control) and 9 (init) are read/write 32-bit registers with no write gating.
- R10: Words 64 to 95 form the descriptor window; word 64+i returns descriptor byte i, zero-extended. The bytes are as follows:
  - byte 0: 0x80
  - byte 1: 0x08
  - byte 2: 0x04
  - byte 31: a density of 64 for `MEM_MB` of 256 or more, 32 for 128 or more, 16 for 64 or more, 4 for 32 or more, and 2 otherwise
  - all other bytes: 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle strobe per reference period |
| busSel | input | 1 | Register access valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWordAddr | input | 10 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| ledOn | output | 1 | LED drive from control bit 0 |
| flashAtZero | output | 1 | Boot flash mapped at address zero |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The bench aims at the lock boundary with several cases:
- oscillator writes made with a near-miss key, with the key held in the upper half of the data word, and just after the key has been overwritten;
- a design that compared all 32 bits, or that latched the key permanently, would accept or refuse the wrong writes.

It writes control values that carry bit 3 and bits other than 0 and 2. A design that stored bit 3 would read it back as set, and a design that held the reset request as a level would keep `resetReq` high into the following cycle.

Set and clear writes are mixed at random on both flag registers and checked against a model. This catches a design that crossed the two copies or that wrote instead of ORing. The counter is checked while `refTick` toggles at random, which catches a design that counted clocks rather than ticks. Reads of the descriptor tail and of the unmapped words check that they return zero.

// File: rtl/cm_sysctl_pkg.sv
package cm_sysctl_pkg;

  localparam logic [31:0] ID_VALUE     = 32'h411A_3001;
  localparam logic [31:0] STAT_VALUE   = 32'h0010_0000;
  localparam logic [15:0] UNLOCK_KEY   = 16'hA05F;
  localparam logic [31:0] OSC_RESET    = 32'h0100_0048;
  localparam logic [31:0] AUX_RESET    = 32'h0007_FEFF;
  localparam logic [31:0] SDRAM_BASE   = 32'h0001_1122;
  localparam logic [31:0] INIT_RESET   = 32'h0000_0112;

  // Write strobes from the decoder to the datapath, one per target.
  typedef struct packed {
    logic osc;
    logic aux;
    logic ctrl;
    logic lock;
    logic sdram;
    logic init;
    logic flagSet;
    logic flagClr;
    logic nvSet;
    logic nvClr;
  } wrStrobes_t;

  typedef enum logic [3:0] {
    RD_ZERO, RD_ID, RD_STAT, RD_OSC, RD_CTRL, RD_LOCK, RD_AUX,
    RD_SDRAM, RD_INIT, RD_COUNT, RD_FLAGS, RD_NVFLAGS, RD_DESC
  } rdSel_t;

  function automatic logic [31:0] sizeCode(input int memMb);
    if (memMb >= 256)      return 32'h10;
    else if (memMb >= 128) return 32'h0C;
    else if (memMb >= 64)  return 32'h08;
    else if (memMb >= 32)  return 32'h04;
    else                   return 32'h00;
  endfunction

  function automatic logic [7:0] descByte(input int idx, input int memMb);
    case (idx)
      0:  return 8'h80;
      1:  return 8'h08;
      2:  return 8'h04;
      31: begin
        if (memMb >= 256)      return 8'd64;
        else if (memMb >= 128) return 8'd32;
        else if (memMb >= 64)  return 8'd16;
        else if (memMb >= 32)  return 8'd4;
        else                   return 8'd2;
      end
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cm_sysctl_ctrl.sv
module cm_sysctl_ctrl
  import cm_sysctl_pkg::*;
#(
  parameter int AW         = 10,
  parameter int DESC_WBASE = 64,
  parameter int DESC_WORDS = 32,
  localparam int DIW       = $clog2(DESC_WORDS)
) (
  input  logic          busSel,
  input  logic          busWrite,
  input  logic [AW-1:0] busWordAddr,
  output wrStrobes_t    wrStb,
  output rdSel_t        rdSel,
  output logic [DIW-1:0] descIdx
);

  localparam logic [AW-DIW-1:0] DESC_TAG = (AW-DIW)'(DESC_WBASE >> DIW);

  logic doWrite;
  logic inDesc;

  assign doWrite = busSel & busWrite;
  assign inDesc  = (busWordAddr[AW-1:DIW] == DESC_TAG);
  assign descIdx = busWordAddr[DIW-1:0];

  always_comb begin
    wrStb = '0;
    rdSel = RD_ZERO;
    case (int'(busWordAddr))
      0:  rdSel = RD_ID;
      2:  begin rdSel = RD_OSC;   wrStb.osc   = doWrite; end
      3:  begin rdSel = RD_CTRL;  wrStb.ctrl  = doWrite; end
      4:  rdSel = RD_STAT;
      5:  begin rdSel = RD_LOCK;  wrStb.lock  = doWrite; end
      7:  begin rdSel = RD_AUX;   wrStb.aux   = doWrite; end
      8:  begin rdSel = RD_SDRAM; wrStb.sdram = doWrite; end
      9:  begin rdSel = RD_INIT;  wrStb.init  = doWrite; end
      10: rdSel = RD_COUNT;
      12: begin rdSel = RD_FLAGS;   wrStb.flagSet = doWrite; end
      13: wrStb.flagClr = doWrite;
      14: begin rdSel = RD_NVFLAGS; wrStb.nvSet   = doWrite; end
      15: wrStb.nvClr = doWrite;
      default: if (inDesc) rdSel = RD_DESC;
    endcase
  end

endmodule

// File: rtl/cm_sysctl_dp.sv
module cm_sysctl_dp
  import cm_sysctl_pkg::*;
#(
  parameter int MEM_MB     = 128,
  parameter int DESC_WORDS = 32,
  localparam int DIW       = $clog2(DESC_WORDS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           refTick,
  input  wrStrobes_t     wrStb,
  input  rdSel_t         rdSel,
  input  logic [DIW-1:0] descIdx,
  input  logic [31:0]    busWdata,
  output logic [31:0]    busRdata,
  output logic           ledOn,
  output logic           flashAtZero,
  output logic           resetReq
);

  localparam logic [31:0] SDRAM_RESET = SDRAM_BASE | sizeCode(MEM_MB);

  logic [31:0] oscReg, auxReg, sdramReg, initReg, countReg;
  logic [31:0] flagsReg, nvFlagsReg;
  logic [15:0] lockReg;
  logic        ledBit, remapBit;
  logic        unlocked;
  logic [7:0]  descRom [DESC_WORDS];

  for (genvar i = 0; i < DESC_WORDS; i++) begin : g_desc
    assign descRom[i] = descByte(i, MEM_MB);
  end

  assign unlocked = (lockReg == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oscReg     <= OSC_RESET;
      auxReg     <= AUX_RESET;
      sdramReg   <= SDRAM_RESET;
      initReg    <= INIT_RESET;
      lockReg    <= '0;
      ledBit     <= 1'b0;
      remapBit   <= 1'b0;
      flagsReg   <= '0;
      nvFlagsReg <= '0;
      resetReq   <= 1'b0;
    end else begin
      if (wrStb.osc && unlocked) oscReg <= busWdata;
      if (wrStb.aux && unlocked) auxReg <= busWdata;
      if (wrStb.sdram) sdramReg <= busWdata;
      if (wrStb.init)  initReg  <= busWdata;
      if (wrStb.lock)  lockReg  <= busWdata[15:0];
      if (wrStb.ctrl) begin
        ledBit   <= busWdata[0];
        remapBit <= busWdata[2];
      end
      if (wrStb.flagSet) flagsReg <= flagsReg | busWdata;
      else if (wrStb.flagClr) flagsReg <= flagsReg & ~busWdata;
      if (wrStb.nvSet) nvFlagsReg <= nvFlagsReg | busWdata;
      else if (wrStb.nvClr) nvFlagsReg <= nvFlagsReg & ~busWdata;
      resetReq <= wrStb.ctrl & busWdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        countReg <= '0;
    else if (refTick) countReg <= countReg + 32'd1;
  end

  always_comb begin
    case (rdSel)
      RD_ID:      busRdata = ID_VALUE;
      RD_STAT:    busRdata = STAT_VALUE;
      RD_OSC:     busRdata = oscReg;
      RD_CTRL:    busRdata = {29'd0, remapBit, 1'b0, ledBit};
      RD_LOCK:    busRdata = {15'd0, unlocked, lockReg};
      RD_AUX:     busRdata = auxReg;
      RD_SDRAM:   busRdata = sdramReg;
      RD_INIT:    busRdata = initReg;
      RD_COUNT:   busRdata = countReg;
      RD_FLAGS:   busRdata = flagsReg;
      RD_NVFLAGS: busRdata = nvFlagsReg;
      RD_DESC:    busRdata = {24'd0, descRom[descIdx]};
      default:    busRdata = '0;
    endcase
  end

  assign ledOn       = ledBit;
  assign flashAtZero = ~remapBit;

  assert_osc_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.osc && !unlocked) |=> $stable(oscReg));
  assert_aux_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.aux && !unlocked) |=> $stable(auxReg));
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    refTick |=> countReg == $past(countReg) + 32'd1);
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !refTick |=> $stable(countReg));
  assert_reset_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.ctrl && busWdata[3]) |=> resetReq);
  assert_reset_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb.ctrl && busWdata[3]) |=> !resetReq);
  assert_remap_flash_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.ctrl && busWdata[2]) |=> !flashAtZero);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.flagClr |=> (flagsReg & $past(busWdata)) == 32'd0);

endmodule

// File: rtl/cm_sysctl.sv
module cm_sysctl
  import cm_sysctl_pkg::*;
#(
  parameter int MEM_MB     = 128,
  parameter int AW         = 10,
  parameter int DESC_WBASE = 64,
  parameter int DESC_WORDS = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refTick,
  input  logic          busSel,
  input  logic          busWrite,
  input  logic [AW-1:0] busWordAddr,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  output logic          ledOn,
  output logic          flashAtZero,
  output logic          resetReq
);

  localparam int DIW = $clog2(DESC_WORDS);

  wrStrobes_t     wrStb;
  rdSel_t         rdSel;
  logic [DIW-1:0] descIdx;

  cm_sysctl_ctrl #(
    .AW(AW), .DESC_WBASE(DESC_WBASE), .DESC_WORDS(DESC_WORDS)
  ) u_ctrl (
    .busSel(busSel), .busWrite(busWrite), .busWordAddr(busWordAddr),
    .wrStb(wrStb), .rdSel(rdSel), .descIdx(descIdx)
  );

  cm_sysctl_dp #(
    .MEM_MB(MEM_MB), .DESC_WORDS(DESC_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .wrStb(wrStb), .rdSel(rdSel), .descIdx(descIdx), .busWdata(busWdata),
    .busRdata(busRdata), .ledOn(ledOn), .flashAtZero(flashAtZero),
    .resetReq(resetReq)
  );

endmodule

// File: tb/cm_sysctl_bench.sv
module cm_sysctl_bench;

  localparam int MEM_MB = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [9:0]  busWordAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        ledOn, flashAtZero, resetReq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // bench model
  logic [31:0] mOsc, mAux, mSdram, mInit, mFlags, mNv, mCount;
  logic [15:0] mLock;
  logic        mLed, mRemap;

  cm_sysctl #(.MEM_MB(MEM_MB)) u_cm_sysctl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .busSel(busSel),
    .busWrite(busWrite), .busWordAddr(busWordAddr), .busWdata(busWdata),
    .busRdata(busRdata), .ledOn(ledOn), .flashAtZero(flashAtZero),
    .resetReq(resetReq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) mCount <= 32'd0;
    else if (refTick) mCount <= mCount + 32'd1;
  end

  always @(negedge clk) refTick <= ($urandom % 3) == 0;

  function automatic logic [31:0] sdramReset(input int mb);
    logic [31:0] c;
    c = (mb >= 256) ? 32'h10 : (mb >= 128) ? 32'h0C : (mb >= 64) ? 32'h08 :
        (mb >= 32) ? 32'h04 : 32'h0;
    return 32'h0001_1122 | c;
  endfunction

  function automatic logic [31:0] descExp(input int i, input int mb);
    if (i == 0) return 32'h80;
    if (i == 1) return 32'h08;
    if (i == 2) return 32'h04;
    if (i == 31) return (mb >= 256) ? 32'd64 : (mb >= 128) ? 32'd32 :
                        (mb >= 64) ? 32'd16 : (mb >= 32) ? 32'd4 : 32'd2;
    return 32'h0;
  endfunction

  function automatic logic [31:0] expRead(input int w);
    case (w)
      0:  return 32'h411A_3001;
      4:  return 32'h0010_0000;
      2:  return mOsc;
      3:  return {29'd0, mRemap, 1'b0, mLed};
      5:  return (mLock == 16'hA05F) ? 32'h0001_A05F : {16'd0, mLock};
      7:  return mAux;
      8:  return mSdram;
      9:  return mInit;
      10: return mCount;
      12: return mFlags;
      14: return mNv;
      default: if (w >= 64 && w < 96) return descExp(w - 64, MEM_MB);
               else return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(input int w);
    case (w)
      5: return "R2";
      2, 7: return "R3";
      3: return "R4";
      10: return "R7";
      8, 9: return "R9";
      12, 13, 14, 15: return "R6";
      default: return (w >= 64 && w < 96) ? "R10" : "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mOsc = 32'h0100_0048; mAux = 32'h0007_FEFF; mSdram = sdramReset(MEM_MB);
    mInit = 32'h112; mFlags = 0; mNv = 0; mLock = 0; mLed = 0; mRemap = 0;
  endtask

  task automatic modelWrite(input int w, input logic [31:0] d);
    case (w)
      2:  if (mLock == 16'hA05F) mOsc = d;
      7:  if (mLock == 16'hA05F) mAux = d;
      3:  begin mLed = d[0]; mRemap = d[2]; end
      5:  mLock = d[15:0];
      8:  mSdram = d;
      9:  mInit = d;
      12: mFlags = mFlags | d;
      13: mFlags = mFlags & ~d;
      14: mNv = mNv | d;
      15: mNv = mNv & ~d;
      default: ;
    endcase
  endtask

  // write; resetReq is checked just after the write edge (R5)
  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busWordAddr = 10'(w); busWdata = d;
    modelWrite(w, d);
    @(posedge clk); #1;
    check("R5", {31'd0, resetReq}, {31'd0, (w == 3) && d[3]});
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input int w, input string req);
    @(negedge clk);
    busSel = 1; busWrite = 0; busWordAddr = 10'(w);
    #1;
    check(req, busRdata, expRead(w));
    busSel = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // reset state, R8
    check("R4", {30'd0, ledOn, flashAtZero}, 32'h1);
    check("R5", {31'd0, resetReq}, 32'd0);
    for (int w = 0; w < 16; w++) rd(w, (w == 10) ? "R7" : "R8");

    // fixed words and unmapped, R1
    rd(1, "R1"); rd(6, "R1"); rd(11, "R1"); rd(20, "R1"); rd(63, "R1");
    rd(96, "R1"); rd(127, "R1"); rd(1023, "R1");
    wr(20, 32'hFFFF_FFFF); wr(6, 32'h1234);
    for (int w = 0; w < 16; w++) rd(w, "R1");

    // descriptor window, R10
    for (int i = 0; i < 32; i++) rd(64 + i, "R10");

    // lock boundary, R2/R3
    wr(2, 32'hDEAD_BEEF); rd(2, "R3");
    wr(5, 32'h0000_A05E); rd(5, "R2"); wr(7, 32'h1111); rd(7, "R3");
    wr(5, 32'hA05F_0000); rd(5, "R2"); wr(2, 32'h2222); rd(2, "R3");
    wr(5, 32'hFFFF_A05F); rd(5, "R2");
    wr(2, 32'hCAFE_0001); rd(2, "R3"); wr(7, 32'hCAFE_0007); rd(7, "R3");
    wr(5, 32'h0000_0001); rd(5, "R2");
    wr(7, 32'h5555); rd(7, "R3");

    // control, R4/R5
    wr(3, 32'hFFFF_FFFF); rd(3, "R4");
    check("R4", {30'd0, ledOn, flashAtZero}, 32'h2);
    @(posedge clk); #1; check("R5", {31'd0, resetReq}, 32'd0);
    wr(3, 32'h0000_0008); rd(3, "R5");
    check("R4", {30'd0, ledOn, flashAtZero}, 32'h1);
    wr(3, 32'h0000_0001);
    check("R4", {30'd0, ledOn, flashAtZero}, 32'h3);

    // flags, R6
    wr(12, 32'h0000_00F0); wr(14, 32'h0F00_0000);
    rd(12, "R6"); rd(14, "R6");
    wr(13, 32'h0000_0030); wr(15, 32'hFFFF_FFFF); rd(12, "R6"); rd(14, "R6");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int w;
      logic [31:0] d;
      int pick;
      pick = $urandom % 20;
      w = (pick < 16) ? pick : (pick == 16) ? 64 + ($urandom % 64) : 10;
      d = $urandom;
      if (w == 5 && ($urandom % 2)) d = {$urandom, 16'hA05F};
      if ($urandom % 2) wr(w, d);
      else rd(w, reqOf(w));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule